// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a recovery watchdog for a small processor subsystem. Software arms it by writing a two-byte key (1EH, then E1H) to a write-only register port. The same key, written again while armed, restarts the count. Once armed, a 14-bit counter advances on each cycle in which the machine-cycle enable is high. When the counter reaches its all-ones value, the block drives a reset pulse whose length in oscillator clocks depends on a clock-mode input. It then returns to the disarmed state.

The only way to disarm the block is the hardware reset or the end of its own reset pulse. The counter cannot be read or written, so software sees only the armed flag, through the parent system. All logic runs on the oscillator clock, and the machine-cycle input acts as a clock enable.

The control FSM has three states. `WD_OFF` is disarmed, `WD_RUN` is armed and counting, and `WD_FIRE` is driving the reset pulse. It has three transitions. *arm* (`WD_OFF`→`WD_RUN`) happens when the key completes. *expire* (`WD_RUN`→`WD_FIRE`) happens when the counter holds 3FFFH. *release* (`WD_FIRE`→`WD_OFF`) happens when the pulse length has elapsed. The key recogniser has two states and three transitions. `KS_IDLE` goes to `KS_HALF` on a 1EH write. `KS_HALF` goes back to `KS_IDLE` on any other write, which either completes the key (E1H) or aborts it. A 1EH write in `KS_HALF` keeps it in `KS_HALF`.

Top module: `keyed_wdog`

## Requirements
- R1: While `rst_n` is low and after its release, `armed_o` and `rst_pulse_o` are 0. The reset is asynchronous, so a reset applied in the middle of operation clears both outputs at once.
- R2: A write of 1EH followed by a write of E1H arms the block. Idle cycles between the two writes are allowed. `armed_o` is 1 after the clock edge that takes the E1H write.
- R3: While disarmed, no amount of enable pulses produces a reset pulse.
- R4: A write other than E1H directly after a 1EH write aborts the key, so 1EH, 55H, E1H does not arm. A repeated 1EH restarts the key, so 1EH, 1EH, E1H arms.
- R5: While armed, the counter advances by one on each clock edge where `tick_i` is 1. The arming edge itself clears the counter and does not advance it. With `tick_i` held at 1, `rst_pulse_o` rises on the 16384th edge after the arming edge.
- R6: A complete key while armed clears the counter. The next pulse then comes 16384 enabled edges after the edge that takes the E1H write. A key that completes while the counter already holds 3FFFH does not prevent the pulse.
- R7: While armed, no write pattern (single bytes, partial or aborted keys) drops `armed_o` before the pulse.
- R8: `rst_pulse_o` stays high for 98 clocks when `mode12_i` is 0 and for 196 clocks when it is 1. The mode is sampled on the edge where the pulse starts. `armed_o` is 0 while the pulse is high.
- R9: After the pulse ends, the block is disarmed. A new key restarts the full count from zero.
- R10: Writes during the pulse are ignored. A 1EH written during the pulse followed by E1H after it does not arm the block.
- R11: Cycles with `tick_i` at 0 do not advance the counter. An armed block with no enable pulses never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| tick_i | input | 1 | Machine-cycle enable, one clock wide per machine cycle |
| wr_i | input | 1 | Write strobe for the key register |
| wdata_i | input | 8 | Write data for the key register |
| mode12_i | input | 1 | Clock mode: 0 selects 98-clock pulse, 1 selects 196-clock pulse |
| rst_pulse_o | output | 1 | Watchdog reset pulse, active high |
| armed_o | output | 1 | High while armed and counting |

## Verification
Every result is due one clock edge after its cause. `armed_o` changes on the edge that takes the E1H write. `rst_pulse_o` rises on the edge after the counter reaches 3FFFH, which is the 16384th enabled edge after the arm or kick edge, and it falls a mode-dependent 98 or 196 edges later. The bench drives inputs and samples outputs only on falling edges. A cycle-level reference model, updated on the same rising edge as the design, is compared against both outputs on every falling edge. Directed checks count falling edges from the arming or kicking write to the first high pulse sample, and then across the pulse, and compare those counts with the exact numbers above.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Key bytes: order matters, first then second
    localparam logic [7:0] KEY_FIRST  = 8'h1E;
    localparam logic [7:0] KEY_SECOND = 8'hE1;

    // Control FSM
    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    // Key recogniser FSM
    typedef enum logic {
        KS_IDLE = 1'b0,
        KS_HALF = 1'b1
    } ks_state_e;

    // Pulse stretcher FSM
    typedef enum logic {
        PS_IDLE = 1'b0,
        PS_BUSY = 1'b1
    } ps_state_e;

endpackage

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
    import wdog_pkg::*;
#(
    parameter int DW = 8,
    parameter logic [DW-1:0] K1 = KEY_FIRST,
    parameter logic [DW-1:0] K2 = KEY_SECOND
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          match_o
);

    ks_state_e state_q, state_d;

    // next-state
    always_comb begin
        state_d = state_q;
        if (flush_i) begin
            state_d = KS_IDLE;
        end else if (wr_i) begin
            unique case (state_q)
                KS_IDLE: state_d = (wdata_i == K1) ? KS_HALF : KS_IDLE;
                KS_HALF: state_d = (wdata_i == K1) ? KS_HALF : KS_IDLE;
                default: state_d = KS_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        match_o = 1'b0;
        unique case (state_q)
            KS_IDLE: match_o = 1'b0;
            KS_HALF: match_o = wr_i && !flush_i && (wdata_i == K2);
            default: match_o = 1'b0;
        endcase
    end

    // R4: a stray write (neither key byte) leaves no half-key behind
    assert_stray_aborts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i != K1 && wdata_i != K2) |=> (state_q == KS_IDLE));

    // R10: flushing blocks completion on the next cycle
    assert_flush_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (state_q == KS_IDLE));

endmodule

// File: rtl/wdog_cycctr.sv
module wdog_cycctr #(
    parameter int W = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic full_o
);

    localparam logic [W-1:0] CMAX = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr_i)    cnt_q <= '0;
        else if (en_i && cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
    end

    always_comb full_o = (cnt_q == CMAX);

    // R5: one step per enabled cycle
    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clr_i && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R11: no enable, no movement
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(cnt_q));

    // R6: a clear returns the count to zero
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch
    import wdog_pkg::*;
#(
    parameter int LEN_A = 98,
    parameter int LEN_B = 196
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sel_i,
    output logic active_o,
    output logic done_o
);

    localparam int LMAX = (LEN_A > LEN_B) ? LEN_A : LEN_B;
    localparam int PW   = $clog2(LMAX + 1);
    localparam logic [PW-1:0] LAST_A = PW'(LEN_A - 1);
    localparam logic [PW-1:0] LAST_B = PW'(LEN_B - 1);

    ps_state_e     state_q, state_d;
    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] last_q;
    logic [PW-1:0] last_sel;
    logic          at_end;

    // length pick: a parameter decides whether the mode input matters at all
    generate
        if (LEN_A == LEN_B) begin : g_fixed
            always_comb last_sel = LAST_A;
        end else begin : g_mode
            always_comb last_sel = sel_i ? LAST_B : LAST_A;
        end
    endgenerate

    always_comb at_end = (pcnt_q == last_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE: if (start_i) state_d = PS_BUSY;
            PS_BUSY: if (at_end)  state_d = PS_IDLE;
            default: state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
            pcnt_q  <= '0;
            last_q  <= LAST_A;
        end else begin
            state_q <= state_d;
            if (state_q == PS_IDLE && start_i) begin
                pcnt_q <= '0;
                last_q <= last_sel;
            end else if (state_q == PS_BUSY && !at_end) begin
                pcnt_q <= pcnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        active_o = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            PS_IDLE: begin active_o = 1'b0; done_o = 1'b0;   end
            PS_BUSY: begin active_o = 1'b1; done_o = at_end; end
            default: begin active_o = 1'b0; done_o = 1'b0;   end
        endcase
    end

    // R8: the running count never passes the latched length
    assert_len_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> (pcnt_q <= last_q));

    // R8: a finished pulse drops the next cycle
    assert_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !active_o);

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import wdog_pkg::*;
#(
    parameter int CNT_W     = 14,
    parameter int DATA_W    = 8,
    parameter int PULSE_SHT = 98,
    parameter int PULSE_LNG = 196
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              mode12_i,
    output logic              rst_pulse_o,
    output logic              armed_o
);

    localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

    wd_state_e state_q, state_d;
    logic      key_ok;
    logic      cnt_full;
    logic      cnt_clr;
    logic      cnt_en;
    logic      fire_start;
    logic      pulse_act;
    logic      pulse_done;
    logic      key_flush;

    always_comb begin
        key_flush  = (state_q == WD_FIRE);
        cnt_clr    = (state_q != WD_RUN) || key_ok;
        cnt_en     = (state_q == WD_RUN) && tick_i;
        fire_start = (state_q == WD_RUN) && cnt_full;
    end

    wdog_keyseq #(
        .DW (DATA_W),
        .K1 (K1),
        .K2 (K2)
    ) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (key_flush),
        .wr_i    (wr_i),
        .wdata_i (wdata_i),
        .match_o (key_ok)
    );

    wdog_cycctr #(
        .W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .en_i   (cnt_en),
        .full_o (cnt_full)
    );

    wdog_stretch #(
        .LEN_A (PULSE_SHT),
        .LEN_B (PULSE_LNG)
    ) u_pulse (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (fire_start),
        .sel_i    (mode12_i),
        .active_o (pulse_act),
        .done_o   (pulse_done)
    );

    // next-state: arm, expire, release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_OFF:  if (key_ok)     state_d = WD_RUN;
            WD_RUN:  if (cnt_full)   state_d = WD_FIRE;
            WD_FIRE: if (pulse_done) state_d = WD_OFF;
            default: state_d = WD_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WD_OFF;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        rst_pulse_o = 1'b0;
        armed_o     = 1'b0;
        unique case (state_q)
            WD_OFF:  begin rst_pulse_o = 1'b0; armed_o = 1'b0; end
            WD_RUN:  begin rst_pulse_o = 1'b0; armed_o = 1'b1; end
            WD_FIRE: begin rst_pulse_o = 1'b1; armed_o = 1'b0; end
            default: begin rst_pulse_o = 1'b0; armed_o = 1'b0; end
        endcase
    end

    // R1: both outputs quiet while reset is held
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_quiet_in_reset_R1: assert (!armed_o && !rst_pulse_o);
        end
    end

    // R3: disarmed never leads straight to a pulse
    assert_no_fire_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed_o && !rst_pulse_o) |=> !rst_pulse_o);

    // R7: armed persists until the counter is full
    assert_stays_armed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !cnt_full) |=> armed_o);

    // R5: a full counter while armed starts the pulse next cycle
    assert_full_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && cnt_full) |=> rst_pulse_o);

    // R8: the pin pulse and the stretcher agree
    assert_pulse_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_pulse_o == pulse_act);

    // R9: pulse end leaves the block disarmed
    assert_release_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_pulse_o) |-> !armed_o);

endmodule

// File: tb/tb_keyed_wdog.sv
`timescale 1ns/1ps
module tb_keyed_wdog;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic       mode12_i = 1'b0;
    logic       rst_pulse_o;
    logic       armed_o;

    int vectors = 0;
    int errors  = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    always #2 clk = ~clk;

    keyed_wdog dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .wr_i        (wr_i),
        .wdata_i     (wdata_i),
        .mode12_i    (mode12_i),
        .rst_pulse_o (rst_pulse_o),
        .armed_o     (armed_o)
    );

    // ---------------- reference model built from the requirements --------
    int m_state;   // 0 off, 1 armed, 2 pulsing
    int m_cnt;
    bit m_half;
    int m_len;
    int m_pc;

    function automatic int pulse_len(bit m12);
        return m12 ? 196 : 98;
    endfunction

    function automatic bit exp_pulse();
        return m_state == 2;
    endfunction

    function automatic bit exp_armed();
        return m_state == 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_cnt <= 0; m_half <= 1'b0; m_len <= 98; m_pc <= 0;
        end else begin
            bit ok;
            ok = wr_i && m_half && (wdata_i == 8'hE1) && (m_state != 2);
            if (m_state == 2)  m_half <= 1'b0;
            else if (wr_i)     m_half <= (wdata_i == 8'h1E);
            case (m_state)
                0: if (ok) begin m_state <= 1; m_cnt <= 0; end
                1: begin
                    if (m_cnt == 16383) begin
                        m_state <= 2; m_pc <= 0; m_len <= pulse_len(mode12_i);
                    end else if (ok)    m_cnt <= 0;
                    else if (tick_i)    m_cnt <= m_cnt + 1;
                end
                default: begin
                    if (m_pc == m_len - 1) begin m_state <= 0; m_cnt <= 0; end
                    else m_pc <= m_pc + 1;
                end
            endcase
        end
    end

    // ---------------- checking ------------------------------------------
    task automatic chk(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cmp_model();
        chk(cur_req, "rst_pulse_o vs model", rst_pulse_o, exp_pulse());
        chk(cur_req, "armed_o vs model", armed_o, exp_armed());
    endtask

    // one clock: rising edge, then sample at the falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic wr_byte(logic [7:0] d);
        wr_i = 1'b1; wdata_i = d;
        step();
        wr_i = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", "armed_o in reset", armed_o, 0);
        chk("R1", "rst_pulse_o in reset", rst_pulse_o, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        step();
        chk("R1", "armed_o after reset", armed_o, 0);
    endtask

    // counts sampled cycles until the pulse is seen; limit guards a hang
    task automatic cycles_to_pulse(output int k);
        k = 0;
        while (!rst_pulse_o && k < 40000) begin step(); k++; end
    endtask

    task automatic pulse_width(output int k);
        k = 0;
        while (rst_pulse_o && k < 1000) begin step(); k++; end
    endtask

    initial begin
        #(190000 * 4);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int k;
        void'($urandom(32'd1234));

        // R1 reset state
        cur_req = "R1";
        apply_reset();

        // R3: disarmed, enable pulses forever, no pulse
        cur_req = "R3";
        tick_i = 1'b1;
        repeat (17000) step();
        chk("R3", "no pulse while disarmed", rst_pulse_o, 0);

        // R4: aborted key does not arm; restarted key does
        cur_req = "R4";
        wr_byte(8'h1E); wr_byte(8'h55); wr_byte(8'hE1);
        chk("R4", "1E,55,E1 leaves disarmed", armed_o, 0);
        wr_byte(8'hE1);
        chk("R4", "lone E1 leaves disarmed", armed_o, 0);
        wr_byte(8'h1E); wr_byte(8'h1E);
        chk("R4", "1E,1E not yet armed", armed_o, 0);

        // R2 + R5: E1 arms; pulse on the 16384th edge after arming
        cur_req = "R5";
        wr_byte(8'hE1);
        chk("R2", "armed after key", armed_o, 1);
        mode12_i = 1'b0;
        cycles_to_pulse(k);
        chk("R5", "edges from arm to pulse", k, 16384);
        pulse_width(k);
        chk("R8", "pulse width mode 0", k, 98);
        chk("R9", "disarmed after pulse", armed_o, 0);

        // R2 with gaps, R7 stray writes, R6 kick, R8 long mode
        cur_req = "R6";
        wr_byte(8'h1E); step(); step(); wr_byte(8'hE1);
        chk("R2", "armed with idle gap", armed_o, 1);
        repeat (9000) step();
        wr_byte(8'h00); wr_byte(8'hFF); wr_byte(8'hE1);
        wr_byte(8'h1E); wr_byte(8'h42);
        chk("R7", "stray writes keep armed", armed_o, 1);
        chk("R6", "no pulse before kick", rst_pulse_o, 0);
        wr_byte(8'h1E); wr_byte(8'hE1);
        mode12_i = 1'b1;
        cycles_to_pulse(k);
        chk("R6", "edges from kick to pulse", k, 16384);
        // R10: writes during pulse are ignored
        cur_req = "R10";
        wr_byte(8'h1E);
        pulse_width(k);
        chk("R8", "pulse width mode 1 (one write cycle before)", k + 1, 196);
        wr_byte(8'hE1);
        chk("R10", "key split across pulse does not arm", armed_o, 0);

        // R6 corner: kick landing while counter holds 3FFF still fires
        cur_req = "R6";
        mode12_i = 1'b0;
        wr_byte(8'h1E); wr_byte(8'hE1);
        repeat (16382) step();
        wr_byte(8'h1E);          // counter reaches 3FFF on this edge
        wr_byte(8'hE1);          // key completes while full
        chk("R6", "late kick does not prevent pulse", rst_pulse_o, 1);
        pulse_width(k);
        chk("R8", "pulse width mode 0 again", k, 98);

        // R11: armed, no enable pulses, never fires
        cur_req = "R11";
        wr_byte(8'h1E); wr_byte(8'hE1);
        tick_i = 1'b0;
        repeat (20000) step();
        chk("R11", "no pulse without ticks", rst_pulse_o, 0);
        chk("R11", "still armed", armed_o, 1);

        // R1: asynchronous reset mid-operation
        apply_reset();

        // random: frequent writes with keys, partial enables
        cur_req = "R7";
        for (int i = 0; i < 20000; i++) begin
            int r;
            r = $urandom_range(99);
            wr_i = (r < 30);
            r = $urandom_range(9);
            wdata_i = (r < 4) ? 8'h1E : (r < 8) ? 8'hE1 : 8'($urandom);
            tick_i = ($urandom_range(9) < 7);
            mode12_i = $urandom_range(1);
            step();
        end

        // random: rare writes, steady enables, overflows happen
        cur_req = "R9";
        tick_i = 1'b1;
        for (int i = 0; i < 40000; i++) begin
            wr_i = ($urandom_range(3999) == 0) || (armed_o == 1'b0 && $urandom_range(49) == 0);
            wdata_i = $urandom_range(1) ? 8'h1E : 8'hE1;
            mode12_i = $urandom_range(1);
            step();
        end
        wr_i = 1'b0;

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule